// File: doc/BRIEF.md
# UDP Packet Transmit Framer

The block sits between an internal 64-bit streaming source and the transmit side of a 10G Ethernet MAC. It runs at the 156.25 MHz datapath rate. A frame from the source opens with one header word. That word carries the frame's payload length in bytes and an index into a small destination table. Each table entry holds a destination MAC address, IPv4 address and UDP port. The framer cuts the payload into UDP packets. Each packet takes at most a programmed number of 64-bit words. The framer puts an Ethernet, IPv4 and UDP header in front of every packet, and holds the output idle for a programmed number of cycles after each packet.

Every packet starts with six header words, 48 bytes in all. These are the 42 bytes of Ethernet, IPv4 and UDP headers, then a 6-byte sequence field: two zero bytes and a 32-bit big-endian packet number. With this field the receiver can put a frame back together, and the payload stays aligned to whole words. Payload words pass straight from the input to the output. When the output stalls, the input stalls in the same cycle. The source configuration (MAC, IP, port), the packet size and the gap are static inputs. Software changes them only between frames.

Top module: `udp_tx_framer`

## Requirements
- R1: After reset, out_valid, out_last and tbl_wr_rej are 0 and in_ready is 1.
- R2: When the framer is idle, an input word with in_sop set is taken as a frame header: bits [3:0] give the table index and bits [31:16] give the payload length L in bytes. The header word itself is not forwarded. An input word without in_sop that arrives while idle is consumed and dropped. A frame with L = 0 produces no output.
- R3: Each packet starts with six header words, with byte n of the packet on out_data[8k+7:8k] of word n/8, where k = n mod 8. Bytes 0-5 hold the destination MAC, 6-11 the source MAC, 12-13 hold 0x0800, 14-15 hold 0x45 0x00, 16-17 the IPv4 total length 34+D, 18-21 are zero, 22-23 hold 0x40 0x11, 24-25 the header checksum, 26-29 the source IP and 30-33 the destination IP. Bytes 34-35 hold the source port, 36-37 the destination port, 38-39 the UDP length 14+D and 40-43 are zero. All multi-byte fields are big-endian, and D is the number of payload bytes in the packet.
- R4: The IPv4 header checksum is the one's complement of the one's-complement sum of the ten 16-bit header words, with the checksum field taken as zero. The UDP checksum (bytes 40-41) is zero.
- R5: Each packet carries min(remaining, 8*N) payload bytes, where N is cfg_pkt_words and N = 0 is treated as 1. The payload words are the frame's data words, in order, with none lost or repeated.
- R6: out_last marks the final payload word of each packet. Its out_keep is the low r lanes, where r = D mod 8, or all eight lanes when r = 0. Every other output word has out_keep = 0xFF.
- R7: Bytes 44-47 carry the packet number within the frame. It starts at 0 and rises by 1 per packet.
- R8: With out_ready held high, exactly cfg_gap cycles with out_valid low separate the last word of one packet from the first header word of the next.
- R9: tbl_wdata holds the MAC in [95:48], the IP in [47:16] and the port in [15:0]. A write taken while the framer is idle updates the entry and leaves tbl_wr_rej at 0. A write at any other time is ignored, and tbl_wr_rej goes high in the following cycle.
- R10: While out_valid is high and out_ready is low, the output word, keep and last stay unchanged, and no input word is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_sop | input | 1 | Marks the frame header word |
| in_data | input | 64 | Input header or payload word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 64 | Packet word, byte 0 on lane 0 |
| out_keep | output | 8 | Byte-valid lanes |
| out_last | output | 1 | Final word of a packet |
| tbl_we | input | 1 | Destination table write strobe |
| tbl_addr | input | 4 | Destination table entry |
| tbl_wdata | input | 96 | Entry value {MAC, IP, port} |
| tbl_wr_rej | output | 1 | Pulse: a write was refused while busy |
| cfg_src_mac | input | 48 | Source MAC address |
| cfg_src_ip | input | 32 | Source IPv4 address |
| cfg_src_port | input | 16 | Source UDP port |
| cfg_pkt_words | input | 11 | Payload words per packet |
| cfg_gap | input | 8 | Idle cycles after each packet |

## Verification
Faults in the word counter or the remaining-length register show up as a wrong out_last position or a wrong keep pattern. They also show up in the length and checksum bytes of the next header, no later than one packet after the fault. A wrong packet number or table index corrupts header word 5 or word 0 of the very packet affected. A wrong gap count moves the first header word of the following packet by whole cycles. The bench therefore stamps the capture cycle of every output word. It compares every word, lane mask and last flag against a model built from the requirements, and it checks the stall behaviour under a pseudo-random ready pattern.

// File: rtl/udp_tx_pkg.sv
package udp_tx_pkg;

  localparam int HDR_WORDS = 6;
  localparam int HDR_SLOTS = 64;

  typedef struct packed {
    logic [47:0] mac;
    logic [31:0] ip;
    logic [15:0] port;
  } dest_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2,
    ST_GAP  = 2'd3
  } tx_state_e;

  // one's-complement checksum over the fixed IPv4 header (id, flags, offset zero)
  function automatic logic [15:0] ipv4_csum(input logic [15:0] tot_len,
                                            input logic [31:0] sip,
                                            input logic [31:0] dip);
    logic [19:0] s;
    s = 20'h04500 + 20'(tot_len) + 20'h04011
      + 20'(sip[31:16]) + 20'(sip[15:0]) + 20'(dip[31:16]) + 20'(dip[15:0]);
    s = 20'(s[15:0]) + 20'(s[19:16]);
    s = 20'(s[15:0]) + 20'(s[19:16]);
    return ~s[15:0];
  endfunction

endpackage

// File: rtl/udp_dest_table.sv
module udp_dest_table
  import udp_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  dest_t            wdata,
  input  logic [IDX_W-1:0] raddr,
  output dest_t            rdata
);

  dest_t ent [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      ent[waddr] <= wdata;
    end
  end

  assign rdata = ent[raddr];

endmodule

// File: rtl/udp_hdr_gen.sv
module udp_hdr_gen
  import udp_tx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  dest_t             dst,
  input  logic [47:0]       src_mac,
  input  logic [31:0]       src_ip,
  input  logic [15:0]       src_port,
  input  logic [LEN_W-1:0]  data_bytes,
  input  logic [31:0]       pkt_num,
  input  logic [2:0]        sel,
  output logic [63:0]       word
);

  logic [7:0]  hb [HDR_SLOTS];
  logic [15:0] ip_len;
  logic [15:0] udp_len;
  logic [15:0] csum;

  assign ip_len  = 16'(data_bytes) + 16'd34;
  assign udp_len = 16'(data_bytes) + 16'd14;
  assign csum    = ipv4_csum(ip_len, src_ip, dst.ip);

  always_comb begin
    for (int i = 0; i < HDR_SLOTS; i++) hb[i] = 8'h00;
    for (int i = 0; i < 6; i++) begin
      hb[i]     = dst.mac[47-8*i -: 8];
      hb[6+i]   = src_mac[47-8*i -: 8];
    end
    hb[12] = 8'h08;
    hb[14] = 8'h45;
    hb[16] = ip_len[15:8];   hb[17] = ip_len[7:0];
    hb[22] = 8'h40;          hb[23] = 8'h11;
    hb[24] = csum[15:8];     hb[25] = csum[7:0];
    for (int i = 0; i < 4; i++) begin
      hb[26+i] = src_ip[31-8*i -: 8];
      hb[30+i] = dst.ip[31-8*i -: 8];
      hb[44+i] = pkt_num[31-8*i -: 8];
    end
    hb[34] = src_port[15:8]; hb[35] = src_port[7:0];
    hb[36] = dst.port[15:8]; hb[37] = dst.port[7:0];
    hb[38] = udp_len[15:8];  hb[39] = udp_len[7:0];
  end

  for (genvar k = 0; k < 8; k++) begin : g_lane
    assign word[8*k +: 8] = hb[{sel, 3'(k)}];
  end

endmodule

// File: rtl/udp_tx_framer.sv
module udp_tx_framer
  import udp_tx_pkg::*;
#(
  parameter int TBL_DEPTH = 16,
  parameter int LEN_W     = 16,
  parameter int PKTW_W    = 11,
  parameter int GAP_W     = 8,
  localparam int IDX_W    = $clog2(TBL_DEPTH),
  localparam int CMP_W    = (LEN_W > PKTW_W + 3) ? LEN_W : PKTW_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic [63:0]       in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [63:0]       out_data,
  output logic [7:0]        out_keep,
  output logic              out_last,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [95:0]       tbl_wdata,
  output logic              tbl_wr_rej,
  input  logic [47:0]       cfg_src_mac,
  input  logic [31:0]       cfg_src_ip,
  input  logic [15:0]       cfg_src_port,
  input  logic [PKTW_W-1:0] cfg_pkt_words,
  input  logic [GAP_W-1:0]  cfg_gap
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  tx_state_e         state_q, state_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [LEN_W-1:0]  rem_q, rem_n;
  logic [LEN_W-1:0]  wcnt_q, wcnt_n;
  logic [31:0]       pnum_q, pnum_n;
  logic [GAP_W-1:0]  gap_q, gap_n;
  logic              rej_q, rej_n;

  logic [PKTW_W-1:0] eff_words;
  logic [CMP_W-1:0]  rem_x, maxb_x, pb_x;
  logic [LEN_W-1:0]  pkt_bytes, pkt_wm1, rem_after;
  logic [2:0]        tail;
  logic [7:0]        tail_keep;
  logic              last_beat;
  logic              tbl_wr_ok;
  dest_t             dst;
  logic [63:0]       hdr_word;

  // payload bytes of the current packet (R5)
  assign eff_words = (cfg_pkt_words == '0) ? PKTW_W'(1) : cfg_pkt_words;
  assign rem_x     = CMP_W'(rem_q);
  assign maxb_x    = CMP_W'({eff_words, 3'b000});
  assign pb_x      = (rem_x < maxb_x) ? rem_x : maxb_x;
  assign pkt_bytes = LEN_W'(pb_x);
  assign pkt_wm1   = (pkt_bytes - LEN_W'(1)) >> 3;
  assign rem_after = rem_q - pkt_bytes;
  assign tail      = pkt_bytes[2:0];
  assign tail_keep = (tail == 3'd0) ? 8'hFF : (8'hFF >> (4'd8 - {1'b0, tail}));
  assign last_beat = (state_q == ST_PAY) && (wcnt_q == pkt_wm1);

  assign tbl_wr_ok = tbl_we && (state_q == ST_IDLE);

  udp_dest_table #(.DEPTH(TBL_DEPTH)) u_tbl (
    .clk   (clk),
    .we    (tbl_wr_ok),
    .waddr (tbl_addr),
    .wdata (dest_t'(tbl_wdata)),
    .raddr (idx_q),
    .rdata (dst)
  );

  udp_hdr_gen #(.LEN_W(LEN_W)) u_hdr (
    .dst        (dst),
    .src_mac    (cfg_src_mac),
    .src_ip     (cfg_src_ip),
    .src_port   (cfg_src_port),
    .data_bytes (pkt_bytes),
    .pkt_num    (pnum_q),
    .sel        (wcnt_q[2:0]),
    .word       (hdr_word)
  );

  // output and input handshake
  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = hdr_word;
    out_keep  = 8'hFF;
    out_last  = 1'b0;
    unique case (state_q)
      ST_IDLE: in_ready = 1'b1;
      ST_HDR:  out_valid = 1'b1;
      ST_PAY: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        out_data  = in_data;
        out_keep  = last_beat ? tail_keep : 8'hFF;
        out_last  = last_beat;
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    rem_n   = rem_q;
    wcnt_n  = wcnt_q;
    pnum_n  = pnum_q;
    gap_n   = gap_q;
    rej_n   = tbl_we && (state_q != ST_IDLE);
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid && in_sop) begin
          idx_n  = in_data[IDX_W-1:0];
          rem_n  = in_data[16 +: LEN_W];
          wcnt_n = '0;
          pnum_n = '0;
          if (in_data[16 +: LEN_W] != '0) state_n = ST_HDR;
        end
      end
      ST_HDR: begin
        if (out_ready) begin
          if (wcnt_q == LEN_W'(HDR_WORDS - 1)) begin
            wcnt_n  = '0;
            state_n = ST_PAY;
          end else begin
            wcnt_n = wcnt_q + LEN_W'(1);
          end
        end
      end
      ST_PAY: begin
        if (in_valid && out_ready) begin
          if (last_beat) begin
            wcnt_n = '0;
            rem_n  = rem_after;
            pnum_n = pnum_q + 32'd1;
            if (cfg_gap != '0) begin
              gap_n   = cfg_gap;
              state_n = ST_GAP;
            end else begin
              state_n = (rem_after == '0) ? ST_IDLE : ST_HDR;
            end
          end else begin
            wcnt_n = wcnt_q + LEN_W'(1);
          end
        end
      end
      default: begin
        if (gap_q == GAP_W'(1)) state_n = (rem_q == '0) ? ST_IDLE : ST_HDR;
        else                    gap_n   = gap_q - GAP_W'(1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rem_q   <= '0;
      wcnt_q  <= '0;
      pnum_q  <= '0;
      gap_q   <= '0;
      rej_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      rem_q   <= rem_n;
      wcnt_q  <= wcnt_n;
      pnum_q  <= pnum_n;
      gap_q   <= gap_n;
      rej_q   <= rej_n;
    end
  end

  assign tbl_wr_rej = rej_q;

endmodule

// File: rtl/udp_tx_framer_chk.sv
module udp_tx_framer_chk #(
  parameter int GAP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [63:0]      out_data,
  input logic [7:0]       out_keep,
  input logic             out_last,
  input logic             tbl_we,
  input logic             tbl_wr_rej,
  input logic [GAP_W-1:0] cfg_gap
);

  logic [GAP_W:0] idle_cnt;
  logic           armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      armed    <= 1'b0;
    end else if (out_valid && out_ready && out_last) begin
      idle_cnt <= '0;
      armed    <= 1'b1;
    end else if (out_valid) begin
      armed    <= 1'b0;
    end else if (armed && (idle_cnt != '1)) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_keep) && $stable(out_last)); // R10
  AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !out_ready |-> !out_valid); // R10
  AST_KEEP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> out_keep == 8'hFF); // R6
  AST_KEEP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_keep[0] && ((out_keep & (out_keep + 8'd1)) == 8'd0)); // R6
  AST_REJ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_rej |-> $past(tbl_we)); // R9
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    armed && out_valid |-> idle_cnt >= (GAP_W+1)'(cfg_gap)); // R8

endmodule

bind udp_tx_framer udp_tx_framer_chk #(.GAP_W(GAP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_keep   (out_keep),
  .out_last   (out_last),
  .tbl_we     (tbl_we),
  .tbl_wr_rej (tbl_wr_rej),
  .cfg_gap    (cfg_gap)
);

// File: tb/sim_udp_tx_framer.sv
module sim_udp_tx_framer;

  localparam int CLK_PERIOD = 10;
  localparam int CAP_MAX    = 4096;
  localparam logic [47:0] SRC_MAC  = 48'h02_11_22_33_44_55;
  localparam logic [31:0] SRC_IP   = 32'hC0A8_0001;
  localparam logic [15:0] SRC_PORT = 16'h1F90;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sop, in_ready;
  logic [63:0] in_data;
  logic        out_valid, out_ready, out_last;
  logic [63:0] out_data;
  logic [7:0]  out_keep;
  logic        tbl_we, tbl_wr_rej;
  logic [3:0]  tbl_addr;
  logic [95:0] tbl_wdata;
  logic [10:0] cfg_pkt_words;
  logic [7:0]  cfg_gap;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit bp_on   = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [47:0] m_mac  [16];
  logic [31:0] m_ip   [16];
  logic [15:0] m_port [16];

  logic [63:0] cap_data [CAP_MAX];
  logic [7:0]  cap_keep [CAP_MAX];
  logic        cap_last [CAP_MAX];
  int          cap_cyc  [CAP_MAX];
  int          cap_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  udp_tx_framer u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_keep(out_keep), .out_last(out_last),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .tbl_wr_rej(tbl_wr_rej),
    .cfg_src_mac(SRC_MAC), .cfg_src_ip(SRC_IP), .cfg_src_port(SRC_PORT),
    .cfg_pkt_words(cfg_pkt_words), .cfg_gap(cfg_gap)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // ready pattern for the sink
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp_on ? lfsr[0] : 1'b1;
    end
  end

  // capture of accepted output words
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (cap_n < CAP_MAX) begin
        cap_data[cap_n] = out_data;
        cap_keep[cap_n] = out_keep;
        cap_last[cap_n] = out_last;
        cap_cyc[cap_n]  = cyc;
      end
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_hdr(input int idx, input int db, input int pn, input int w);
    logic [7:0]  b [48];
    logic [31:0] tl, ul, s;
    logic [15:0] cs;
    logic [63:0] r;
    tl = 32'(34 + db);
    ul = 32'(14 + db);
    for (int i = 0; i < 48; i++) b[i] = 8'h00;
    for (int i = 0; i < 6; i++) begin
      b[i]   = m_mac[idx][47-8*i -: 8];
      b[6+i] = SRC_MAC[47-8*i -: 8];
    end
    b[12] = 8'h08; b[14] = 8'h45;
    b[16] = tl[15:8]; b[17] = tl[7:0];
    b[22] = 8'h40; b[23] = 8'h11;
    s = 32'h4500 + tl + 32'h4011 + 32'(SRC_IP[31:16]) + 32'(SRC_IP[15:0])
      + 32'(m_ip[idx][31:16]) + 32'(m_ip[idx][15:0]);
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    cs = ~s[15:0];
    b[24] = cs[15:8]; b[25] = cs[7:0];
    for (int i = 0; i < 4; i++) begin
      b[26+i] = SRC_IP[31-8*i -: 8];
      b[30+i] = m_ip[idx][31-8*i -: 8];
      b[44+i] = 8'(pn >> (24 - 8*i));
    end
    b[34] = SRC_PORT[15:8];      b[35] = SRC_PORT[7:0];
    b[36] = m_port[idx][15:8];   b[37] = m_port[idx][7:0];
    b[38] = ul[15:8];            b[39] = ul[7:0];
    for (int k = 0; k < 8; k++) r[8*k +: 8] = b[8*w + k];
    return r;
  endfunction

  function automatic logic [63:0] data_word(input logic [15:0] tag, input int k);
    return {tag, 16'h0000, 32'(k)};
  endfunction

  function automatic logic [7:0] lane_mask(input int n);
    return (n == 0) ? 8'hFF : 8'((1 << n) - 1);
  endfunction

  task automatic push_word(input logic [63:0] d, input bit sop);
    bit took = 1'b0;
    in_valid = 1'b1;
    in_data  = d;
    in_sop   = sop;
    while (!took) begin
      @(negedge clk);
      took = in_ready;
      @(posedge clk);
      #1;
    end
  endtask

  task automatic send_frame(input int idx, input int len, input logic [15:0] tag);
    push_word({32'h0, 16'(len), 12'h0, 4'(idx)}, 1'b1);
    for (int k = 0; k < (len + 7) / 8; k++) push_word(data_word(tag, k), 1'b0);
    in_valid = 1'b0;
    in_sop   = 1'b0;
  endtask

  task automatic tbl_write(input int idx, input logic [47:0] mac, input logic [31:0] ip,
                           input logic [15:0] port, input bit expect_ok);
    tbl_we    = 1'b1;
    tbl_addr  = 4'(idx);
    tbl_wdata = {mac, ip, port};
    @(posedge clk);
    #1;
    tbl_we = 1'b0;
    @(negedge clk);
    chk(tbl_wr_rej == !expect_ok, "R9", "reject flag", 64'(tbl_wr_rej), 64'(!expect_ok));
    if (expect_ok) begin
      m_mac[idx] = mac; m_ip[idx] = ip; m_port[idx] = port;
    end
    @(posedge clk);
    #1;
  endtask

  // compares the captured stream from index cs against one expected frame
  task automatic check_frame(input int cs, input int idx, input int len, input int pktw,
                             input logic [15:0] tag, input int gap, output int ce);
    int rem = len;
    int pn = 0;
    int k = 0;
    int c = cs;
    int eff = (pktw == 0) ? 1 : pktw;
    while (rem > 0) begin
      int db = (rem < eff * 8) ? rem : eff * 8;
      int nw = (db + 7) / 8;
      if (c + 6 + nw > cap_n || c + 6 + nw > CAP_MAX) begin
        chk(1'b0, "R5", "missing output words", 64'(cap_n), 64'(c + 6 + nw));
        ce = cap_n;
        return;
      end
      if (pn > 0 && gap >= 0)
        chk(cap_cyc[c] - cap_cyc[c-1] == gap + 1, "R8", "gap cycles",
            64'(cap_cyc[c] - cap_cyc[c-1] - 1), 64'(gap));
      for (int w = 0; w < 6; w++) begin
        chk(cap_data[c] == exp_hdr(idx, db, pn, w),
            (w == 3) ? "R4" : ((w == 5) ? "R7" : "R3"), "header word",
            cap_data[c], exp_hdr(idx, db, pn, w));
        chk(cap_keep[c] == 8'hFF && !cap_last[c], "R6", "header keep/last",
            {55'h0, cap_last[c], cap_keep[c]}, 64'h0FF);
        c++;
      end
      for (int j = 0; j < nw; j++) begin
        logic [7:0] ek = (j == nw - 1) ? lane_mask(db % 8) : 8'hFF;
        logic [63:0] m;
        for (int l = 0; l < 8; l++) m[8*l +: 8] = {8{ek[l]}};
        chk((cap_data[c] & m) == (data_word(tag, k) & m), "R5", "payload word",
            cap_data[c] & m, data_word(tag, k) & m);
        chk(cap_keep[c] == ek && cap_last[c] == (j == nw - 1), "R6", "payload keep/last",
            {55'h0, cap_last[c], cap_keep[c]}, {55'h0, (j == nw - 1), ek});
        c++;
        k++;
      end
      rem -= db;
      pn++;
    end
    ce = c;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!out_valid && !out_last && !tbl_wr_rej && in_ready, "R1", "reset outputs",
        {60'h0, out_valid, out_last, tbl_wr_rej, in_ready}, 64'h1);
    @(posedge clk);
    #1;
  endtask

  task automatic t_basic();
    int cs, ce;
    tbl_write(3, 48'h00_1B_21_AA_00_03, 32'hC0A8_0A03, 16'hC350, 1'b1);
    tbl_write(7, 48'h00_1B_21_AA_00_07, 32'hC0A8_0A07, 16'hC357, 1'b1);
    cfg_pkt_words = 11'd2;
    cfg_gap = 8'd3;
    cs = cap_n;
    send_frame(3, 40, 16'hA001);
    repeat (20) @(posedge clk);
    #1;
    check_frame(cs, 3, 40, 2, 16'hA001, 3, ce);
    chk(cap_n == ce, "R2", "word count of split frame", 64'(cap_n), 64'(ce));
  endtask

  task automatic t_short_packet();
    int cs, ce;
    cfg_pkt_words = 11'd4;
    cfg_gap = 8'd1;
    cs = cap_n;
    send_frame(7, 21, 16'hA002);
    repeat (20) @(posedge clk);
    #1;
    check_frame(cs, 7, 21, 4, 16'hA002, 1, ce);
    chk(cap_n == ce, "R6", "single short packet words", 64'(cap_n), 64'(ce));
  endtask

  task automatic t_zero_size_no_gap();
    int cs, ce;
    cfg_pkt_words = 11'd0;
    cfg_gap = 8'd0;
    cs = cap_n;
    send_frame(3, 17, 16'hA003);
    repeat (20) @(posedge clk);
    #1;
    check_frame(cs, 3, 17, 0, 16'hA003, 0, ce);
    chk(cap_n == ce, "R5", "size zero treated as one word", 64'(cap_n), 64'(ce));
  endtask

  task automatic t_backpressure();
    int cs, ce;
    cfg_pkt_words = 11'd3;
    cfg_gap = 8'd2;
    bp_on = 1'b1;
    cs = cap_n;
    send_frame(7, 100, 16'hA004);
    repeat (60) @(posedge clk);
    #1;
    bp_on = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check_frame(cs, 7, 100, 3, 16'hA004, -1, ce);
    chk(cap_n == ce, "R10", "no lost or repeated words under stall", 64'(cap_n), 64'(ce));
  endtask

  task automatic t_busy_write();
    int cs, ce;
    tbl_write(2, 48'h00_1B_21_AA_00_02, 32'hC0A8_0A02, 16'hC352, 1'b1);
    cfg_pkt_words = 11'd2;
    cfg_gap = 8'd2;
    cs = cap_n;
    fork
      send_frame(2, 64, 16'hA005);
      begin
        repeat (12) @(posedge clk);
        #1;
        tbl_write(2, 48'hFF_EE_DD_CC_BB_AA, 32'h0101_0101, 16'h0BAD, 1'b0);
      end
    join
    repeat (20) @(posedge clk);
    #1;
    check_frame(cs, 2, 64, 2, 16'hA005, 2, ce);
    cs = cap_n;
    send_frame(2, 8, 16'hA006);
    repeat (20) @(posedge clk);
    #1;
    check_frame(cs, 2, 8, 2, 16'hA006, 2, ce);
    chk(cap_n == ce, "R9", "refused write left entry unchanged", 64'(cap_n), 64'(ce));
  endtask

  task automatic t_stray_and_empty();
    int cs, ce;
    cfg_pkt_words = 11'd1;
    cfg_gap = 8'd0;
    cs = cap_n;
    push_word(64'hDEAD_BEEF_0000_0001, 1'b0);
    in_valid = 1'b0;
    push_word({32'h0, 16'd0, 12'h0, 4'd3}, 1'b1);
    in_valid = 1'b0;
    in_sop = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    chk(cap_n == cs, "R2", "stray word and empty frame produce no output", 64'(cap_n), 64'(cs));
    send_frame(3, 9, 16'hA007);
    repeat (20) @(posedge clk);
    #1;
    check_frame(cs, 3, 9, 1, 16'hA007, 0, ce);
    chk(cap_n == ce, "R2", "only the real frame emitted", 64'(cap_n), 64'(ce));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sop = 1'b0;
    in_data = '0;
    tbl_we = 1'b0;
    tbl_addr = '0;
    tbl_wdata = '0;
    cfg_pkt_words = 11'd2;
    cfg_gap = 8'd1;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_basic();
    t_short_packet();
    t_zero_size_no_gap();
    t_backpressure();
    t_busy_write();
    t_stray_and_empty();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule